// File: doc/BRIEF.md
# Serial EEPROM Slave

This block behaves as the target end of a four-wire serial EEPROM link of the common 25-series kind. A master lowers the chip-select line, clocks in an 8-bit command most significant bit first and, for array commands, a 16-bit address. Then it either clocks data bytes in or reads data bytes out on the serial output. The stored bytes sit in an internal byte-wide RAM whose depth is a power-of-two parameter. A small status byte holds a write-enable flag and a two-bit protection field. The protection field shields the upper quarter, the upper half or all of the array against writes.

All four serial inputs are treated as asynchronous. They pass through two-flop synchronisers into the system clock domain, and a serial clock rising edge is found by comparing the synchronised level with its value one system clock earlier. The serial clock must therefore stay high for at least two system clocks and low for at least two system clocks. The block is meant to sit behind a host that bit-bangs the link, for example to emulate save memory in a cartridge or a board model.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the status byte reads 0x00, the serial output is high and the first bits clocked in are taken as a command.
- R2: Input bits are shifted in most significant bit first, one per rising serial-clock edge, and only while chip-select is low and hold is high. Rising edges that occur while hold is low are discarded.
- R3: Chip-select high aborts any command. The bit count and command are cleared, the serial output goes high within three system clocks, a partly received data byte is never stored, and the next low period starts a fresh command.
- R4: Command 0x06 sets status bit 1 (write enable) and command 0x04 clears it; each then ignores further clocks until chip-select rises. Command 0x05 shifts out the status byte and repeats it for as long as clocks continue.
- R5: Any command code other than 0x01 to 0x06 has no effect, and all clocks that follow it are ignored until chip-select rises.
- R6: Command 0x01 takes one byte. Only its bits 3:2 are copied into status bits 3:2, bit 1 keeps its value and every other status bit reads zero.
- R7: Command 0x02 followed by a 16-bit address and data bytes stores each byte only when status bit 1 is set.
- R8: With a depth of D bytes, protection field 01 (status bits 3:2) blocks writes at addresses of 3D/4 and above, 10 blocks addresses of D/2 and above, 11 blocks every address and 00 blocks none.
- R9: After each byte of a write, only the low 7 address bits advance, so a burst wraps inside its 128-byte page and the upper address bits stay fixed.
- R10: Command 0x03 followed by a 16-bit address outputs the byte at that address most significant bit first, one bit per rising serial-clock edge. The address then advances across page boundaries and wraps from the last byte to address 0.
- R11: Address bits above those needed for the configured depth are ignored.
- R12: The write-enable bit is never cleared by an array write or a status write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sck_i | input | 1 | Serial clock from the master, asynchronous |
| hold_n_i | input | 1 | Hold, active low; freezes the serial interface |
| si_i | input | 1 | Serial data from the master |
| so_o | output | 1 | Serial data to the master |

## Verification
The main function is driven with single bursts, page-crossing write bursts and read bursts that cross a page boundary and then the end of the array. Together these separate the page-local write counter from the full-width read counter. Writes are repeated under each protection setting at addresses just below and at each protection threshold, so an off-by-one boundary or a swapped field encoding shows up as a changed or unchanged byte. Extra serial clock pulses with hold low, an unknown command followed by a valid command code, and a chip-select rise in the middle of a data byte confirm that ignored stimulus leaves status and memory unchanged. A behavioural model built from the requirements predicts the serial output on every system clock.

// File: rtl/seep_pkg.sv
package seep_pkg;

    typedef enum logic [2:0] {
        PH_OPCODE = 3'd0,
        PH_ADDR   = 3'd1,
        PH_WDATA  = 3'd2,
        PH_RDATA  = 3'd3,
        PH_PARK   = 3'd4
    } phase_e;

    localparam logic [7:0] CMD_SET_STAT = 8'h01;
    localparam logic [7:0] CMD_WR_ARRAY = 8'h02;
    localparam logic [7:0] CMD_RD_ARRAY = 8'h03;
    localparam logic [7:0] CMD_WR_OFF   = 8'h04;
    localparam logic [7:0] CMD_GET_STAT = 8'h05;
    localparam logic [7:0] CMD_WR_ON    = 8'h06;

    localparam int WEN_BIT = 1;

    // Decide whether a protection field covers an address, given the two
    // most significant array address bits.
    function automatic logic fence_covers(input logic [1:0] fence, input logic [1:0] top);
        logic hit;
        unique case (fence)
            2'b00:   hit = 1'b0;
            2'b01:   hit = (top == 2'b11);
            2'b10:   hit = top[1];
            default: hit = 1'b1;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/seep_sync.sv
module seep_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o
);

    typedef struct packed {
        logic [W-1:0] st1;
        logic [W-1:0] st2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.st1  = raw_i;
        s_d.st2  = s_q.st1;
        s_d.prev = s_q.st2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st1  <= RST_VAL;
            s_q.st2  <= RST_VAL;
            s_q.prev <= RST_VAL;
        end else begin
            s_q <= s_d;
        end
    end

    assign lvl_o  = s_q.st2;
    assign rise_o = s_q.st2 & ~s_q.prev;

    // R2: an edge is reported for one system clock only
    p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/seep_guard.sv
module seep_guard (
    input  logic [1:0] fence_i,
    input  logic       wen_i,
    input  logic [1:0] top_i,
    output logic       allow_o
);
    import seep_pkg::*;

    always_comb begin
        allow_o = wen_i && !fence_covers(fence_i, top_i);
    end

endmodule

// File: rtl/seep_array.sv
module seep_array #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
        rdata_q <= mem_q[raddr_i];
    end

    assign rdata_o = rdata_q;

    // R7: a store never targets an undefined address
    p_store_addr_known_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> !$isunknown(waddr_i));

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic hold_n_i,
    input  logic si_i,
    output logic so_o
);
    import seep_pkg::*;

    localparam int ADR_BITS  = 16;
    localparam int IX_CS     = 0;
    localparam int IX_SCK    = 1;
    localparam int IX_HOLD   = 2;
    localparam int IX_SI     = 3;
    localparam logic [3:0] PIN_RST = 4'b0101;

    typedef struct packed {
        phase_e              ph;
        logic [7:0]          cmd;
        logic [3:0]          cnt;
        logic [7:0]          sh;
        logic [ADR_BITS-1:0] adr_sh;
        logic [ADDR_W-1:0]   addr;
        logic [7:0]          stat;
        logic                so;
        logic                pend;
        logic                wr_go;
        logic [ADDR_W-1:0]   wr_addr;
        logic [7:0]          wr_data;
    } core_t;

    core_t r_d, r_q;

    logic [3:0]        pin_lvl, pin_rise;
    logic              cs_s, hold_s, si_s, clk_edge;
    logic              allow;
    logic [7:0]        rd_byte;
    logic [7:0]        byte_nx;
    logic [7:0]        cmd_nx;
    logic [ADR_BITS-1:0] adr_nx;
    logic [PAGE_W-1:0] page_lo;

    seep_sync #(.W(4), .RST_VAL(PIN_RST)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({si_i, hold_n_i, sck_i, cs_n_i}),
        .lvl_o  (pin_lvl),
        .rise_o (pin_rise)
    );

    assign cs_s     = pin_lvl[IX_CS];
    assign hold_s   = pin_lvl[IX_HOLD];
    assign si_s     = pin_lvl[IX_SI];
    assign clk_edge = pin_rise[IX_SCK];

    seep_guard u_guard (
        .fence_i (r_q.stat[3:2]),
        .wen_i   (r_q.stat[WEN_BIT]),
        .top_i   (r_q.addr[ADDR_W-1 -: 2]),
        .allow_o (allow)
    );

    seep_array #(.AW(ADDR_W), .DW(8)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (r_q.wr_go),
        .waddr_i (r_q.wr_addr),
        .wdata_i (r_q.wr_data),
        .raddr_i (r_d.addr),
        .rdata_o (rd_byte)
    );

    assign cmd_nx  = {r_q.cmd[6:0], si_s};
    assign adr_nx  = {r_q.adr_sh[ADR_BITS-2:0], si_s};
    assign byte_nx = {r_q.sh[6:0], si_s};
    assign page_lo = r_q.addr[PAGE_W-1:0] + 1'b1;

    always_comb begin
        r_d       = r_q;
        r_d.wr_go = 1'b0;
        r_d.pend  = 1'b0;
        if (r_q.pend) begin
            r_d.sh = rd_byte;
        end
        if (cs_s) begin
            r_d.ph  = PH_OPCODE;
            r_d.cnt = '0;
            r_d.cmd = '0;
            r_d.so  = 1'b1;
        end else if (hold_s && clk_edge) begin
            r_d.cnt = r_q.cnt + 4'd1;
            unique case (r_q.ph)
                PH_OPCODE: begin
                    r_d.cmd = cmd_nx;
                    if (r_q.cnt == 4'd7) begin
                        r_d.cnt = '0;
                        unique case (cmd_nx)
                            CMD_SET_STAT: begin
                                r_d.sh = '0;
                                r_d.ph = PH_WDATA;
                            end
                            CMD_WR_ARRAY, CMD_RD_ARRAY: begin
                                r_d.adr_sh = '0;
                                r_d.ph     = PH_ADDR;
                            end
                            CMD_WR_OFF: begin
                                r_d.stat[WEN_BIT] = 1'b0;
                                r_d.ph            = PH_PARK;
                            end
                            CMD_GET_STAT: begin
                                r_d.sh = r_q.stat;
                                r_d.ph = PH_RDATA;
                            end
                            CMD_WR_ON: begin
                                r_d.stat[WEN_BIT] = 1'b1;
                                r_d.ph            = PH_PARK;
                            end
                            default: r_d.ph = PH_PARK;
                        endcase
                    end
                end
                PH_ADDR: begin
                    r_d.adr_sh = adr_nx;
                    if (r_q.cnt == 4'(ADR_BITS - 1)) begin
                        r_d.cnt  = '0;
                        r_d.addr = adr_nx[ADDR_W-1:0];
                        if (r_q.cmd[0]) begin
                            r_d.ph   = PH_RDATA;
                            r_d.pend = 1'b1;
                        end else begin
                            r_d.sh = '0;
                            r_d.ph = PH_WDATA;
                        end
                    end
                end
                PH_WDATA: begin
                    r_d.sh = byte_nx;
                    if (r_q.cnt == 4'd7) begin
                        r_d.cnt = '0;
                        if (r_q.cmd[0]) begin
                            r_d.stat = {4'b0000, byte_nx[3:2], r_q.stat[WEN_BIT], 1'b0};
                            r_d.ph   = PH_PARK;
                        end else begin
                            r_d.wr_go   = allow;
                            r_d.wr_addr = r_q.addr;
                            r_d.wr_data = byte_nx;
                            r_d.sh      = '0;
                            r_d.addr    = {r_q.addr[ADDR_W-1:PAGE_W], page_lo};
                        end
                    end
                end
                PH_RDATA: begin
                    r_d.so = r_q.sh[3'd7 - r_q.cnt[2:0]];
                    if (r_q.cnt == 4'd7) begin
                        r_d.cnt = '0;
                        if (r_q.cmd == CMD_RD_ARRAY) begin
                            r_d.addr = r_q.addr + 1'b1;
                            r_d.pend = 1'b1;
                        end
                    end
                end
                default: r_d.cnt = r_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ph      <= PH_OPCODE;
            r_q.cmd     <= '0;
            r_q.cnt     <= '0;
            r_q.sh      <= '0;
            r_q.adr_sh  <= '0;
            r_q.addr    <= '0;
            r_q.stat    <= '0;
            r_q.so      <= 1'b1;
            r_q.pend    <= 1'b0;
            r_q.wr_go   <= 1'b0;
            r_q.wr_addr <= '0;
            r_q.wr_data <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign so_o = r_q.so;

    // R3: a deselected link drives the output high on the next clock
    p_so_high_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> so_o);

    // R2: while held, the serial state does not move
    p_hold_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && !hold_s) |=> ($stable(r_q.ph) && $stable(r_q.cnt) && $stable(r_q.cmd)));

    // R4: status only changes on an accepted serial clock edge
    p_stat_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(clk_edge && hold_s && !cs_s) |=> $stable(r_q.stat));

    // R8: no store leaves while writes are disabled or fully fenced
    p_store_allowed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.wr_go |-> (r_q.stat[WEN_BIT] && (r_q.stat[3:2] != 2'b11)));

    // R10: byte phases never count beyond eight bits
    p_byte_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph != PH_ADDR) |-> (r_q.cnt < 4'd8));

endmodule

// File: tb/tb_serial_eeprom_slave.sv
`timescale 1ns/1ps
module tb_serial_eeprom_slave;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, si = 1'b0;
    logic so_o;
    int   checks = 0, errors = 0;
    bit   done = 0;

    always #2.5 clk = ~clk;

    serial_eeprom_slave #(.ADDR_W(AW), .PAGE_W(7)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck),
        .hold_n_i(hold_n), .si_i(si), .so_o(so_o)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0] mmem [DEPTH];
    logic m1_cs, m1_sck, m1_hold, m1_si, m2_cs, m2_sck, m2_hold, m2_si, mprev;
    int   mph, mcnt, mshift, madr;
    logic [7:0] mop, mbuf, mstat;
    logic mso;

    always @(posedge clk) begin
        if (!rst_n) begin
            m1_cs = 1; m1_sck = 0; m1_hold = 1; m1_si = 0;
            m2_cs = 1; m2_sck = 0; m2_hold = 1; m2_si = 0; mprev = 0;
            mph = 0; mcnt = 0; mop = 0; mbuf = 0; madr = 0; mstat = 0; mso = 1; mshift = 0;
        end else begin
            logic rise, c, h, d;
            rise = m2_sck && !mprev; c = m2_cs; h = m2_hold; d = m2_si;
            mprev = m2_sck;
            m2_cs = m1_cs; m2_sck = m1_sck; m2_hold = m1_hold; m2_si = m1_si;
            m1_cs = cs_n; m1_sck = sck; m1_hold = hold_n; m1_si = si;
            if (c) begin
                mph = 0; mcnt = 0; mop = 0; mso = 1;
            end else if (h && rise) begin
                case (mph)
                    0: begin
                        mop = {mop[6:0], d}; mcnt++;
                        if (mcnt == 8) begin
                            mcnt = 0;
                            if (mop == 1) begin mbuf = 0; mph = 2; end
                            else if (mop == 2 || mop == 3) begin mshift = 0; mph = 1; end
                            else if (mop == 4) begin mstat[1] = 0; mph = 4; end
                            else if (mop == 5) begin mbuf = mstat; mph = 3; end
                            else if (mop == 6) begin mstat[1] = 1; mph = 4; end
                            else mph = 4;
                        end
                    end
                    1: begin
                        mshift = mshift * 2 + int'(d); mcnt++;
                        if (mcnt == 16) begin
                            mcnt = 0; madr = mshift % DEPTH;
                            if (mop == 3) begin mbuf = mmem[madr]; mph = 3; end
                            else begin mbuf = 0; mph = 2; end
                        end
                    end
                    2: begin
                        mbuf = {mbuf[6:0], d}; mcnt++;
                        if (mcnt == 8) begin
                            mcnt = 0;
                            if (mop == 1) begin
                                mstat = (mstat & 8'h02) | (mbuf & 8'h0C); mph = 4;
                            end else begin
                                bit ok;
                                case (mstat[3:2])
                                    2'd0: ok = 1;
                                    2'd1: ok = madr < (DEPTH * 3) / 4;
                                    2'd2: ok = madr < DEPTH / 2;
                                    default: ok = 0;
                                endcase
                                if (mstat[1] && ok) mmem[madr] = mbuf;
                                mbuf = 0;
                                madr = (madr / 128) * 128 + ((madr % 128) + 1) % 128;
                            end
                        end
                    end
                    3: begin
                        mso = mbuf[7 - mcnt]; mcnt++;
                        if (mcnt == 8) begin
                            mcnt = 0;
                            if (mop == 3) begin madr = (madr + 1) % DEPTH; mbuf = mmem[madr]; end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done && !$isunknown(mso)) begin
            checks++;
            if (so_o !== mso) begin
                errors++;
                $display("FAIL R10 model: so_o actual %b expected %b at %0t", so_o, mso, $time);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bitx(input logic b, output logic r);
        si = b; sck = 0; tick(3);
        sck = 1; tick(4);
        r = so_o; sck = 0;
    endtask

    task automatic bytex(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            logic r;
            bitx(tx[i], r);
            rx[i] = r;
        end
    endtask

    task automatic sel();
        cs_n = 0; tick(3);
    endtask

    task automatic desel();
        sck = 0; tick(2); cs_n = 1; tick(4);
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] x;
        sel(); bytex(op, x); desel();
    endtask

    task automatic rdsr(output logic [7:0] v);
        logic [7:0] x;
        sel(); bytex(8'h05, x); bytex(8'h00, v); desel();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] x;
        sel(); bytex(8'h01, x); bytex(v, x); desel();
    endtask

    task automatic wr1(input logic [15:0] a, input logic [7:0] v);
        logic [7:0] x;
        sel(); bytex(8'h02, x); bytex(a[15:8], x); bytex(a[7:0], x); bytex(v, x); desel();
    endtask

    task automatic rd2(input logic [15:0] a, output logic [7:0] b0, output logic [7:0] b1);
        logic [7:0] x;
        sel(); bytex(8'h03, x); bytex(a[15:8], x); bytex(a[7:0], x);
        bytex(8'h00, b0); bytex(8'h00, b1); desel();
    endtask

    // ---------------- scenario ----------------
    initial begin
        logic [7:0] v, w, x;
        logic r;
        tick(4); rst_n = 1; tick(3);

        chk("R1 so_o after reset", so_o, 1);
        rdsr(v); chk("R1 status after reset", v, 8'h00);

        // R2: write-enable command with two ignored edges while held
        sel();
        for (int i = 7; i >= 4; i--) bitx(i == 6 || i == 5 ? 1'b0 : 1'b0, r);
        hold_n = 0; tick(3);
        for (int k = 0; k < 2; k++) begin si = 1; sck = 1; tick(4); sck = 0; tick(3); end
        hold_n = 1; tick(3);
        bitx(0, r); bitx(1, r); bitx(1, r); bitx(0, r);
        desel();
        rdsr(v); chk("R2 held edges ignored, status", v, 8'h02);

        cmd(8'h04); rdsr(v); chk("R4 write disable", v, 8'h00);
        cmd(8'h06); rdsr(v); chk("R4 write enable", v, 8'h02);
        sel(); bytex(8'h05, x); bytex(8'h00, v); bytex(8'h00, w); desel();
        chk("R4 status repeats first", v, 8'h02);
        chk("R4 status repeats second", w, 8'h02);

        wr1(16'h0010, 8'h11);
        rdsr(v); chk("R12 enable kept after array write", v, 8'h02);
        cmd(8'h04); wr1(16'h0010, 8'h5A);
        rd2(16'h0010, v, w); chk("R7 write blocked when disabled", v, 8'h11);
        cmd(8'h06);

        wrsr(8'hFF); rdsr(v); chk("R6 only fence bits taken", v, 8'h0E);
        wrsr(8'h00); rdsr(v); chk("R6 R12 enable kept by status write", v, 8'h02);

        wr1(16'h02FF, 8'hA1); wr1(16'h0300, 8'hA2); wr1(16'h01FF, 8'hA3);
        wr1(16'h0200, 8'hA4); wr1(16'h0000, 8'hA5);
        wrsr(8'h04);
        wr1(16'h02FF, 8'hB1); wr1(16'h0300, 8'hB2);
        rd2(16'h02FF, v, w);
        chk("R8 fence 01 below quarter", v, 8'hB1);
        chk("R8 fence 01 top quarter", w, 8'hA2);
        wrsr(8'h08);
        wr1(16'h01FF, 8'hB3); wr1(16'h0200, 8'hB4);
        rd2(16'h01FF, v, w);
        chk("R8 fence 10 below half", v, 8'hB3);
        chk("R8 fence 10 upper half", w, 8'hA4);
        wrsr(8'h0C);
        wr1(16'h0000, 8'hB6);
        rd2(16'h0000, v, w); chk("R8 fence 11 all", v, 8'hA5);
        wrsr(8'h00);

        wr1(16'h0180, 8'hEE);
        sel(); bytex(8'h02, x); bytex(8'h01, x); bytex(8'h7E, x);
        bytex(8'hC0, x); bytex(8'hC1, x); bytex(8'hC2, x); bytex(8'hC3, x); desel();
        rd2(16'h017E, v, w);
        chk("R9 page burst byte 0", v, 8'hC0);
        chk("R9 page burst byte 1", w, 8'hC1);
        rd2(16'h0100, v, w);
        chk("R9 wrapped to page start", v, 8'hC2);
        chk("R9 wrapped second", w, 8'hC3);

        rd2(16'h017F, v, w);
        chk("R10 read crosses page", w, 8'hEE);
        wr1(16'h03FF, 8'h77);
        rd2(16'h03FF, v, w);
        chk("R10 last byte", v, 8'h77);
        chk("R10 read wraps to zero", w, 8'hA5);

        rd2(16'hFC10, v, w); chk("R11 upper address ignored", v, 8'h11);

        wr1(16'h0020, 8'h33);
        sel(); bytex(8'h02, x); bytex(8'h00, x); bytex(8'h20, x);
        for (int i = 0; i < 4; i++) bitx(1'b1, r);
        desel();
        rd2(16'h0020, v, w); chk("R3 partial byte not stored", v, 8'h33);
        rdsr(v); chk("R3 fresh command after abort", v, 8'h02);
        sel(); bytex(8'h03, x); bytex(8'h00, x); bytex(8'h10, x);
        bitx(1'b0, r); chk("R10 first data bit", r, 0);
        desel(); chk("R3 so_o high after deselect", so_o, 1);

        cmd(8'h04);
        sel(); bytex(8'hAB, x); bytex(8'h06, x); desel();
        rdsr(v); chk("R5 unknown command ignored", v, 8'h00);
        cmd(8'h06); rdsr(v); chk("R5 next command accepted", v, 8'h02);

        tick(10);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule